// File: doc/BRIEF.md
# Serial-Bus Slave with Page-Committed Lockable Memory

This block is a two-wire serial-bus (I2C) target that fronts a small byte-addressed space. It recovers Start and Stop from oversampled SCL and SDA, compares the first byte against a 7-bit device address taken from a port, and then accepts a pointer byte. Written bytes gather in a 16-entry page buffer. Storage is updated only when the host ends the transfer with a Stop, which mimics a nonvolatile program cycle. A read first sets the pointer with a write that carries no data. A repeated Start then switches the direction, and bytes stream out from the pointer onward.

The space holds two general-purpose regions and a lock byte that lets software protect each region on its own. Addresses that are not implemented read as all ones and ignore writes. The bus is sampled with the block clock, which must run well above the SCL rate.

Top module: `i2cpm_slave`

## Requirements
- R1: After reset, `sda_oe_o` is low, every region byte reads 00h and the lock byte at 9Fh reads 00h.
- R2: An address byte whose upper seven bits equal `dev_addr_i` is acknowledged by pulling SDA low in the ninth clock. Any 7-bit value works. A mismatch is not acknowledged, and the block then stays silent on the bus and changes no storage until the next Start.
- R3: In a write transaction the pointer byte and every data byte are acknowledged, and the pointer byte selects the first target address.
- R4: Buffered write data reaches storage only on a Stop. A Start or repeated Start arriving during a write drops the buffered bytes.
- R5: Successive data bytes go to pointer bits [3:0] incremented by one with bits [7:4] held. More than 16 bytes therefore wrap within the page, and a later byte overwrites an earlier one at the same slot.
- R6: A read returns the byte at the pointer first, MSB first. Each byte is driven after a falling SCL edge. The pointer advances by one after every byte the host acknowledges, and a host NACK ends the read with SDA released.
- R7: Bit 0 of the lock byte (9Fh) protects region 0 (A0h–BFh) and bit 1 protects region 1 (C0h–EFh). The lock byte reads back as {6'b0, lock}. Writes to a protected region are acknowledged but leave storage unchanged.
- R8: Reads of any address outside 9Fh and A0h–EFh return FFh, and writes there are ignored. The read pointer wraps from FFh to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_addr_i | input | 7 | Device address the block answers to |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Resolved level of the data line |
| sda_oe_o | output | 1 | When high, the block pulls SDA low |

## Verification
Writes are applied in several forms: short bursts, a burst that crosses the low nibble so the page wrap shows, a 17-byte burst whose last byte lands on the first slot, and a burst cut off by a repeated Start. These tell a Stop-triggered commit apart from immediate writes, and a wrap apart from a carry into the next page. Reads run across the region boundary, across the unimplemented top of the map and through FFh to 00h, which separates pointer increment from region decode. Lock patterns 00, 01 and 03 show that each region is protected independently while its writes are still acknowledged. A wrong address, followed by a change of `dev_addr_i`, shows that matching follows the port and that a mismatched transfer leaves no trace.

// File: rtl/i2cpm_pkg.sv
package i2cpm_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } i2c_st_e;
endpackage

// File: rtl/i2cpm_bus_sync.sv
module i2cpm_bus_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_N-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_N-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_N-2:0], sda_i};
      scl_d  <= scl_o;
      sda_d  <= sda_o;
    end
  end

  assign scl_o      = scl_sh[SYNC_N-1];
  assign sda_o      = sda_sh[SYNC_N-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edge while SCL stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2cpm_page_buf.sv
module i2cpm_page_buf #(
  parameter int unsigned PAGE_N = 16,
  localparam int unsigned IDX_W = $clog2(PAGE_N)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [7:0]             data_i,
  output logic [PAGE_N-1:0][7:0] data_o,
  output logic [PAGE_N-1:0]      valid_o
);
  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[g]  <= '0;
        valid_o[g] <= 1'b0;
      end else if (clr_i) begin
        valid_o[g] <= 1'b0;
      end else if (wr_i && idx_i == IDX_W'(g)) begin
        data_o[g]  <= data_i;
        valid_o[g] <= 1'b1;
      end
    end
  end

  p_clr_empties_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (valid_o == '0));
endmodule

// File: rtl/i2cpm_store.sv
module i2cpm_store #(
  parameter logic [7:0]  R0_BASE   = 8'hA0,
  parameter int unsigned R0_SIZE   = 32,
  parameter int unsigned R1_SIZE   = 48,
  parameter logic [7:0]  LOCK_ADDR = 8'h9F,
  parameter int unsigned PAGE_N    = 16,
  localparam int unsigned IDX_W = $clog2(PAGE_N),
  localparam int unsigned PG_W  = 8 - IDX_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   commit_i,
  input  logic [PG_W-1:0]        page_i,
  input  logic [PAGE_N-1:0][7:0] buf_data_i,
  input  logic [PAGE_N-1:0]      buf_valid_i,
  input  logic [7:0]             rd_addr_i,
  output logic [7:0]             rd_data_o
);
  localparam int unsigned MEM_N = R0_SIZE + R1_SIZE;
  localparam int unsigned OFF_W = $clog2(MEM_N);
  localparam logic [8:0]  R0_LO = 9'(R0_BASE);
  localparam logic [8:0]  R1_LO = R0_LO + 9'(R0_SIZE);
  localparam logic [8:0]  R1_HI = R1_LO + 9'(R1_SIZE);

  logic [7:0] mem_q [MEM_N];
  logic [1:0] lock_q;

  function automatic logic [1:0] region_of(input logic [7:0] a);
    logic [8:0] w;
    w = {1'b0, a};
    return {(w >= R1_LO) && (w < R1_HI), (w >= R0_LO) && (w < R1_LO)};
  endfunction

  logic [PAGE_N-1:0][1:0]       slot_reg;
  logic [PAGE_N-1:0]            slot_lock;
  logic [PAGE_N-1:0][OFF_W-1:0] slot_off;

  for (genvar g = 0; g < PAGE_N; g++) begin : g_addr
    logic [7:0] a;
    assign a            = {page_i, IDX_W'(g)};
    assign slot_reg[g]  = region_of(a);
    assign slot_lock[g] = (a == LOCK_ADDR);
    assign slot_off[g]  = OFF_W'(a - R0_BASE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      for (int i = 0; i < MEM_N; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE_N; i++) begin
        if (buf_valid_i[i]) begin
          if (slot_lock[i]) lock_q <= buf_data_i[i][1:0];
          else if ((slot_reg[i][0] && !lock_q[0]) || (slot_reg[i][1] && !lock_q[1]))
            mem_q[slot_off[i]] <= buf_data_i[i];
        end
      end
    end
  end

  logic [1:0]       rd_reg;
  logic [OFF_W-1:0] rd_off;
  assign rd_reg = region_of(rd_addr_i);
  assign rd_off = OFF_W'(rd_addr_i - R0_BASE);

  always_comb begin
    if (rd_addr_i == LOCK_ADDR) rd_data_o = {6'b0, lock_q};
    else if (|rd_reg)           rd_data_o = mem_q[rd_off];
    else                        rd_data_o = 8'hFF;
  end

  p_commit_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_q[0] != $past(mem_q[0])) |-> $past(commit_i));
  p_region0_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q[0] && $past(lock_q[0])) |-> (mem_q[0] == $past(mem_q[0])));
  p_region1_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q[1] && $past(lock_q[1])) |-> (mem_q[R0_SIZE] == $past(mem_q[R0_SIZE])));
  p_lock_by_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q != $past(lock_q)) |-> $past(commit_i));
endmodule

// File: rtl/i2cpm_slave.sv
module i2cpm_slave
  import i2cpm_pkg::*;
#(
  parameter int unsigned SYNC_N    = 2,
  parameter int unsigned PAGE_N    = 16,
  parameter logic [7:0]  R0_BASE   = 8'hA0,
  parameter int unsigned R0_SIZE   = 32,
  parameter int unsigned R1_SIZE   = 48,
  parameter logic [7:0]  LOCK_ADDR = 8'h9F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [6:0] dev_addr_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  localparam int unsigned IDX_W = $clog2(PAGE_N);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2cpm_bus_sync #(.SYNC_N(SYNC_N)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  i2c_st_e    st_q;
  logic [2:0] cnt_q;
  logic [7:0] rx_q, tx_q, ptr_q;
  logic       rw_q, ack_ph_q, more_q, sda_oe_q;
  logic [7:0] rx_byte, rd_data;

  logic [PAGE_N-1:0][7:0] buf_data;
  logic [PAGE_N-1:0]      buf_valid;
  logic buf_wr, commit, buf_clr, byte_done;

  assign rx_byte   = {rx_q[6:0], sda_s};
  assign byte_done = scl_rise && (cnt_q == 3'd7);
  assign buf_wr    = (st_q == ST_WDATA) && byte_done;
  assign commit    = stop_ev && (|buf_valid);
  assign buf_clr   = start_ev || commit;

  i2cpm_page_buf #(.PAGE_N(PAGE_N)) i_pbuf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .wr_i(buf_wr),
    .idx_i(ptr_q[IDX_W-1:0]), .data_i(rx_byte),
    .data_o(buf_data), .valid_o(buf_valid)
  );

  i2cpm_store #(
    .R0_BASE(R0_BASE), .R0_SIZE(R0_SIZE), .R1_SIZE(R1_SIZE),
    .LOCK_ADDR(LOCK_ADDR), .PAGE_N(PAGE_N)
  ) i_store (
    .clk_i, .rst_ni, .commit_i(commit), .page_i(ptr_q[7:IDX_W]),
    .buf_data_i(buf_data), .buf_valid_i(buf_valid),
    .rd_addr_i(ptr_q), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      ack_ph_q <= 1'b0;
      more_q   <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (start_ev) begin
      st_q     <= ST_ADDR;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_ev) begin
      st_q     <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            rx_q  <= rx_byte;
            cnt_q <= cnt_q + 3'd1;
            ack_ph_q <= 1'b0;
            if (cnt_q == 3'd7) begin
              if (st_q == ST_ADDR) begin
                if (rx_byte[7:1] == dev_addr_i) begin
                  rw_q <= rx_byte[0];
                  st_q <= ST_ADDR_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (st_q == ST_PTR) begin
                ptr_q <= rx_byte;
                st_q  <= ST_PTR_ACK;
              end else begin
                ptr_q[IDX_W-1:0] <= ptr_q[IDX_W-1:0] + 1'b1; // wrap inside page
                st_q <= ST_WDATA_ACK;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            if (!ack_ph_q) begin
              sda_oe_q <= 1'b1;
              ack_ph_q <= 1'b1;
            end else begin
              sda_oe_q <= 1'b0;
              cnt_q    <= '0;
              if (st_q == ST_ADDR_ACK && rw_q) begin
                tx_q     <= rd_data;
                sda_oe_q <= ~rd_data[7];
                st_q     <= ST_RDATA;
              end else if (st_q == ST_ADDR_ACK) begin
                st_q <= ST_PTR;
              end else begin
                st_q <= ST_WDATA;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              sda_oe_q <= 1'b0;
              st_q     <= ST_RDATA_ACK;
            end else begin
              tx_q     <= {tx_q[6:0], 1'b0};
              sda_oe_q <= ~tx_q[6];
              cnt_q    <= cnt_q + 3'd1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) begin
            more_q <= ~sda_s;
            if (!sda_s) ptr_q <= ptr_q + 8'd1;
          end else if (scl_fall) begin
            if (more_q) begin
              tx_q     <= rd_data;
              sda_oe_q <= ~rd_data[7];
              cnt_q    <= '0;
              st_q     <= ST_RDATA;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  p_oe_moves_scl_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q != $past(sda_oe_q)) |-> !$past(scl_s));
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_q);
  p_page_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WDATA_ACK && $past(st_q) == ST_WDATA) |->
      (ptr_q[7:IDX_W] == $past(ptr_q[7:IDX_W])));
endmodule

// File: tb/test_i2cpm_slave.sv
module test_i2cpm_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] dev_addr = 7'h50;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  i2cpm_slave i_i2cpm_slave (
    .clk_i(clk), .rst_ni(rst_n), .dev_addr_i(dev_addr),
    .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model built from the requirements
  logic [7:0] m_mem [256];
  logic [1:0] m_lock = 2'b00;

  function automatic bit m_r0(input logic [7:0] a); return a >= 8'hA0 && a <= 8'hBF; endfunction
  function automatic bit m_r1(input logic [7:0] a); return a >= 8'hC0 && a <= 8'hEF; endfunction

  logic [7:0] wq [$];

  task automatic m_commit(input logic [7:0] ptr);
    for (int k = 0; k < wq.size(); k++) begin
      logic [7:0] a;
      a = {ptr[7:4], 4'(ptr[3:0] + 4'(k))};
      if (a == 8'h9F) begin
        m_lock = wq[k][1:0];
        m_mem[a] = {6'b0, wq[k][1:0]};
      end else if ((m_r0(a) && !m_lock[0]) || (m_r1(a) && !m_lock[1])) begin
        m_mem[a] = wq[k];
      end
    end
  endtask

  // scoreboard
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] act_b;
  event       got_ev;

  initial begin
    logic [7:0] e;
    string t;
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) chk(1'b0, "SB", act_b, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(act_b == e, t, act_b, e);
      end
    end
  end

  // bus master
  task automatic b_start();
    m_scl = 1'b0; wt(Q);
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic b_stop();
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(Q);
  endtask

  task automatic wb(input logic [7:0] d, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = d[i]; wt(Q);
      m_scl = 1'b1; wt(Q);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q/2);
    ack = ~sda_line;
    wt(Q/2);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic rb(input bit give_ack);
    logic [7:0] d;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q);
      m_scl = 1'b1; wt(Q/2);
      d[i] = sda_line;
      wt(Q/2);
      m_scl = 1'b0;
    end
    act_b = d;
    -> got_ev;
    m_sda = ~give_ack; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_scl = 1'b0; wt(Q);
    m_sda = 1'b1;
  endtask

  task automatic wr_txn(input logic [6:0] a7, input logic [7:0] ptr, input bit do_stop, input string tag);
    bit ack;
    b_start();
    wb({a7, 1'b0}, ack); chk(ack, "R2", ack, 1);
    wb(ptr, ack);        chk(ack, "R3", ack, 1);
    for (int k = 0; k < wq.size(); k++) begin
      wb(wq[k], ack);
      chk(ack, tag, ack, 1);
    end
    if (do_stop) begin
      b_stop();
      m_commit(ptr);
    end
    wt(Q);
  endtask

  task automatic rd_txn(input logic [6:0] a7, input logic [7:0] ptr, input int n, input string tag);
    bit ack;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(m_mem[8'(ptr + 8'(k))]);
      tag_q.push_back(tag);
    end
    b_start();
    wb({a7, 1'b0}, ack); chk(ack, "R2", ack, 1);
    wb(ptr, ack);        chk(ack, "R3", ack, 1);
    b_start();
    wb({a7, 1'b1}, ack); chk(ack, "R6", ack, 1);
    for (int k = 0; k < n; k++) rb(k != n - 1);
    b_stop();
    wt(Q);
    chk(sda_oe == 1'b0, "R6", sda_oe, 0);
  endtask

  initial begin
    bit ack;
    for (int a = 0; a < 256; a++)
      m_mem[a] = (a == 8'h9F || m_r0(8'(a)) || m_r1(8'(a))) ? 8'h00 : 8'hFF;
    wt(4);
    rst_n = 1'b1;
    wt(4);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    rd_txn(7'h50, 8'hA0, 4, "R1");
    rd_txn(7'h50, 8'h9F, 1, "R1");

    // basic write, committed on stop
    wq = {}; wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33);
    wr_txn(7'h50, 8'hA0, 1'b1, "R3");
    rd_txn(7'h50, 8'hA0, 3, "R4");

    // interrupted write is dropped
    wq = {}; wq.push_back(8'h99); wq.push_back(8'h98);
    wr_txn(7'h50, 8'hA4, 1'b0, "R4");
    rd_txn(7'h50, 8'hA4, 2, "R4");

    // page wrap
    wq = {}; wq.push_back(8'hAA); wq.push_back(8'hBB); wq.push_back(8'hCC); wq.push_back(8'hDD);
    wr_txn(7'h50, 8'hAE, 1'b1, "R5");
    rd_txn(7'h50, 8'hA0, 2, "R5");
    rd_txn(7'h50, 8'hAE, 3, "R5");
    wq = {};
    for (int k = 0; k < 17; k++) wq.push_back(8'(8'h40 + k));
    wr_txn(7'h50, 8'hB0, 1'b1, "R5");
    rd_txn(7'h50, 8'hB0, 16, "R5");

    // sequential read across the region boundary
    rd_txn(7'h50, 8'hBE, 4, "R6");

    // mismatched address
    b_start();
    wb({7'h51, 1'b0}, ack); chk(!ack, "R2", ack, 0);
    wb(8'hA0, ack);         chk(!ack, "R2", ack, 0);
    wb(8'h5A, ack);         chk(!ack, "R2", ack, 0);
    b_stop(); wt(Q);
    rd_txn(7'h50, 8'hA0, 1, "R2");

    // locks
    wq = {}; wq.push_back(8'hFD);
    wr_txn(7'h50, 8'h9F, 1'b1, "R7");
    rd_txn(7'h50, 8'h9F, 1, "R7");
    wq = {}; wq.push_back(8'h77);
    wr_txn(7'h50, 8'hA2, 1'b1, "R7");
    wq = {}; wq.push_back(8'h5A);
    wr_txn(7'h50, 8'hC0, 1'b1, "R7");
    rd_txn(7'h50, 8'hA2, 1, "R7");
    rd_txn(7'h50, 8'hC0, 1, "R7");
    wq = {}; wq.push_back(8'h03);
    wr_txn(7'h50, 8'h9F, 1'b1, "R7");
    wq = {}; wq.push_back(8'h66);
    wr_txn(7'h50, 8'hC1, 1'b1, "R7");
    rd_txn(7'h50, 8'hC0, 2, "R7");
    rd_txn(7'h50, 8'h9F, 1, "R7");

    // unimplemented space and pointer wrap
    wq = {}; wq.push_back(8'h12);
    wr_txn(7'h50, 8'h10, 1'b1, "R8");
    rd_txn(7'h50, 8'h10, 1, "R8");
    rd_txn(7'h50, 8'hEE, 3, "R8");
    rd_txn(7'h50, 8'hFE, 3, "R8");

    // programmable address
    dev_addr = 7'h13;
    wt(Q);
    rd_txn(7'h13, 8'hA0, 2, "R2");
    b_start();
    wb({7'h50, 1'b0}, ack); chk(!ack, "R2", ack, 0);
    b_stop(); wt(Q);

    wt(20);
    chk(exp_q.size() == 0, "SB", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "WATCHDOG", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule